// File: doc/BRIEF.md
# System-Management Entry Header Capture

This block records the processor context at the moment a management interrupt is taken. One entry strobe, with a cause code, latches the current and next instruction pointers, three control-register images and the I/O-trap details. The block presents the result as one packed header record, which the surrounding logic writes into the header area of management memory. A one-cycle ready strobe marks the cycle in which a freshly captured record is first presented.

When the handler finishes, a resume request makes the block produce the return address. An I/O-trapped instruction must run again, so after a trap entry the return address is the current pointer. After any other entry it is the next pointer. For a repeated string I/O trap the two pointers are stored as the same address. I/O fields carry data only after trap entries and read as zero otherwise. Nothing captured from the I/O operation is ever sent back towards the core.

Cause codes on `entryCause`: 0 = external interrupt, 1 = I/O trap, 2 = software management-interrupt instruction, 3 = treated as an external interrupt.

Top module: `smm_hdr_capture`

## Requirements
- R1: On an accepted entry strobe the record is loaded at that clock edge and `hdrReady` is high for exactly the following cycle. Record layout with default widths, from MSB to LSB: current IP [245:214], next IP [213:182], debug control [181:150], flags register [149:118], control register 0 [117:86], I/O data [85:54], string pointer [53:22], I/O port [21:6], I/O size [5:4], flag nibble [3:0].
- R2: On every entry the debug control, flags register and control register 0 inputs are stored in the record, whatever the cause.
- R3: On a trap entry (cause 1) the record holds the I/O port, size, data and string pointer. Flag bit 1 (I/O valid) is 1, flag bit 2 (input direction) equals `ioDirIn`, and flag bit 3 (repeated string) equals `ioRepString`.
- R4: On a trap entry with `ioRepString` high, the next IP field holds the current IP value.
- R5: On a non-trap entry (cause 0, 2 or 3) the I/O data, string pointer, port and size fields and flag bits 1 to 3 are zero, and the next IP field holds `nextIp` unchanged.
- R6: Flag bit 0 (software entry) is 1 only after a cause 2 entry.
- R7: One cycle after `resumeReq` is sampled high, `resumeValid` is high for one cycle. From then on `resumeAddr` holds the stored current IP if the held record has I/O valid set, and the stored next IP otherwise.
- R8: A resume request does not change the header record. No captured I/O value is driven out through any port other than the record.
- R9: An entry strobe sampled while `hdrReady` is high is ignored. The record keeps the earlier capture, and no second ready pulse follows.
- R10: After reset the record, `hdrReady`, `resumeValid` and `resumeAddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| entryStb | input | 1 | Management-interrupt entry strobe |
| entryCause | input | 2 | Entry cause code |
| curIp | input | IP_W | Instruction executing when the interrupt was seen |
| nextIp | input | IP_W | Instruction to run after leaving the mode |
| ioPort | input | PORT_W | Trapped I/O port address |
| ioSize | input | SIZE_W | Trapped I/O data size code |
| ioData | input | DATA_W | Trapped I/O data value |
| ioDirIn | input | 1 | Trapped access is an input |
| ioRepString | input | 1 | Trapped access is a repeated string instruction |
| ioStrPtr | input | REG_W | String source/destination index value |
| dbgCtl | input | REG_W | Debug control register value |
| flagsReg | input | REG_W | Extended flags register value |
| ctlReg0 | input | REG_W | Control register 0 value |
| resumeReq | input | 1 | Request for the return address |
| hdrRecord | output | HDR_W | Packed header record |
| hdrReady | output | 1 | One-cycle strobe: new record presented |
| resumeValid | output | 1 | One-cycle strobe: return address updated |
| resumeAddr | output | IP_W | Return address |

## Verification
The record and `hdrReady` change at the clock edge that samples the entry strobe. The bench drives inputs at a falling edge and checks both at the next falling edge. It checks one cycle later that `hdrReady` has dropped. It also changes every input right after the capturing edge, which shows that the record comes from the latched values. `resumeAddr` and `resumeValid` are due one edge after `resumeReq` is sampled and are checked at the falling edge after it. The record is checked again at the same point to show it was not changed. The sweep covers every cause code, both direction values and both repeat-string values, each over three pointer patterns, including the all-ones and zero extremes.

// File: rtl/smm_hdr_pkg.sv
package smm_hdr_pkg;

  typedef enum logic [1:0] {
    CauseExt     = 2'd0,
    CauseIoTrap  = 2'd1,
    CauseSwInstr = 2'd2,
    CauseRsvd    = 2'd3
  } causeT;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic resume;
  } ctrlStbT;

  // flag nibble bit positions
  localparam int FlagSw      = 0;
  localparam int FlagIoValid = 1;
  localparam int FlagDirIn   = 2;
  localparam int FlagRepStr  = 3;
  localparam int FlagW       = 4;

endpackage

// File: rtl/smm_hdr_ctrl.sv
module smm_hdr_ctrl
  import smm_hdr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    entryStb,
  input  logic    resumeReq,
  output ctrlStbT ctrlStb,
  output logic    hdrReady,
  output logic    resumeValid
);

  logic presentingQ;
  logic resumeQ;

  // an entry is taken only outside the presenting cycle
  always_comb begin
    ctrlStb.capture = entryStb && !presentingQ;
    ctrlStb.resume  = resumeReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presentingQ <= 1'b0;
      resumeQ     <= 1'b0;
    end else begin
      presentingQ <= ctrlStb.capture;
      resumeQ     <= ctrlStb.resume;
    end
  end

  assign hdrReady    = presentingQ;
  assign resumeValid = resumeQ;

endmodule

// File: rtl/smm_hdr_datapath.sv
module smm_hdr_datapath
  import smm_hdr_pkg::*;
#(
  parameter int IP_W   = 32,
  parameter int PORT_W = 16,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int SIZE_W = 2,
  localparam int HDR_W = 2*IP_W + 4*REG_W + DATA_W + PORT_W + SIZE_W + FlagW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStbT           ctrlStb,
  input  logic [1:0]        entryCause,
  input  logic [IP_W-1:0]   curIp,
  input  logic [IP_W-1:0]   nextIp,
  input  logic [PORT_W-1:0] ioPort,
  input  logic [SIZE_W-1:0] ioSize,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioDirIn,
  input  logic              ioRepString,
  input  logic [REG_W-1:0]  ioStrPtr,
  input  logic [REG_W-1:0]  dbgCtl,
  input  logic [REG_W-1:0]  flagsReg,
  input  logic [REG_W-1:0]  ctlReg0,
  output logic [HDR_W-1:0]  hdrRecord,
  output logic [IP_W-1:0]   resumeAddr
);

  causeT cause;
  logic  isTrap;
  logic  isSw;

  logic [IP_W-1:0]   curIpQ,   nextIpQ,   nextIpD;
  logic [REG_W-1:0]  dbgQ,     eflQ,      cr0Q;
  logic [DATA_W-1:0] dataQ,    dataD;
  logic [REG_W-1:0]  ptrQ,     ptrD;
  logic [PORT_W-1:0] portQ,    portD;
  logic [SIZE_W-1:0] sizeQ,    sizeD;
  logic [FlagW-1:0]  flagQ,    flagD;
  logic [IP_W-1:0]   resumeQ;

  always_comb begin
    cause  = causeT'(entryCause);
    isTrap = (cause == CauseIoTrap);
    isSw   = (cause == CauseSwInstr);

    // repeated string trap collapses both pointers
    nextIpD = (isTrap && ioRepString) ? curIp : nextIp;

    dataD = isTrap ? ioData   : '0;
    ptrD  = isTrap ? ioStrPtr : '0;
    portD = isTrap ? ioPort   : '0;
    sizeD = isTrap ? ioSize   : '0;

    flagD              = '0;
    flagD[FlagSw]      = isSw;
    flagD[FlagIoValid] = isTrap;
    flagD[FlagDirIn]   = isTrap && ioDirIn;
    flagD[FlagRepStr]  = isTrap && ioRepString;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIpQ  <= '0;
      nextIpQ <= '0;
      dbgQ    <= '0;
      eflQ    <= '0;
      cr0Q    <= '0;
      dataQ   <= '0;
      ptrQ    <= '0;
      portQ   <= '0;
      sizeQ   <= '0;
      flagQ   <= '0;
    end else if (ctrlStb.capture) begin
      curIpQ  <= curIp;
      nextIpQ <= nextIpD;
      dbgQ    <= dbgCtl;
      eflQ    <= flagsReg;
      cr0Q    <= ctlReg0;
      dataQ   <= dataD;
      ptrQ    <= ptrD;
      portQ   <= portD;
      sizeQ   <= sizeD;
      flagQ   <= flagD;
    end
  end

  // return target chosen from the held record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resumeQ <= '0;
    end else if (ctrlStb.resume) begin
      resumeQ <= flagQ[FlagIoValid] ? curIpQ : nextIpQ;
    end
  end

  assign hdrRecord  = {curIpQ, nextIpQ, dbgQ, eflQ, cr0Q,
                       dataQ, ptrQ, portQ, sizeQ, flagQ};
  assign resumeAddr = resumeQ;

endmodule

// File: rtl/smm_hdr_capture.sv
module smm_hdr_capture
  import smm_hdr_pkg::*;
#(
  parameter int IP_W   = 32,
  parameter int PORT_W = 16,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int SIZE_W = 2,
  localparam int HDR_W = 2*IP_W + 4*REG_W + DATA_W + PORT_W + SIZE_W + FlagW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              entryStb,
  input  logic [1:0]        entryCause,
  input  logic [IP_W-1:0]   curIp,
  input  logic [IP_W-1:0]   nextIp,
  input  logic [PORT_W-1:0] ioPort,
  input  logic [SIZE_W-1:0] ioSize,
  input  logic [DATA_W-1:0] ioData,
  input  logic              ioDirIn,
  input  logic              ioRepString,
  input  logic [REG_W-1:0]  ioStrPtr,
  input  logic [REG_W-1:0]  dbgCtl,
  input  logic [REG_W-1:0]  flagsReg,
  input  logic [REG_W-1:0]  ctlReg0,
  input  logic              resumeReq,
  output logic [HDR_W-1:0]  hdrRecord,
  output logic              hdrReady,
  output logic              resumeValid,
  output logic [IP_W-1:0]   resumeAddr
);

  ctrlStbT ctrlStb;

  smm_hdr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .entryStb    (entryStb),
    .resumeReq   (resumeReq),
    .ctrlStb     (ctrlStb),
    .hdrReady    (hdrReady),
    .resumeValid (resumeValid)
  );

  smm_hdr_datapath #(
    .IP_W   (IP_W),
    .PORT_W (PORT_W),
    .DATA_W (DATA_W),
    .REG_W  (REG_W),
    .SIZE_W (SIZE_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrlStb     (ctrlStb),
    .entryCause  (entryCause),
    .curIp       (curIp),
    .nextIp      (nextIp),
    .ioPort      (ioPort),
    .ioSize      (ioSize),
    .ioData      (ioData),
    .ioDirIn     (ioDirIn),
    .ioRepString (ioRepString),
    .ioStrPtr    (ioStrPtr),
    .dbgCtl      (dbgCtl),
    .flagsReg    (flagsReg),
    .ctlReg0     (ctlReg0),
    .hdrRecord   (hdrRecord),
    .resumeAddr  (resumeAddr)
  );

endmodule

// File: rtl/smm_hdr_checker.sv
module smm_hdr_checker
  import smm_hdr_pkg::*;
#(
  parameter int IP_W   = 32,
  parameter int PORT_W = 16,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int SIZE_W = 2,
  localparam int HDR_W = 2*IP_W + 4*REG_W + DATA_W + PORT_W + SIZE_W + FlagW
) (
  input logic             clk,
  input logic             rstN,
  input logic             entryStb,
  input logic             resumeReq,
  input logic [HDR_W-1:0] hdrRecord,
  input logic             hdrReady,
  input logic             resumeValid,
  input logic [IP_W-1:0]  resumeAddr
);

  localparam int SizeLo = FlagW;
  localparam int PortLo = SizeLo + SIZE_W;
  localparam int PtrLo  = PortLo + PORT_W;
  localparam int DataLo = PtrLo + REG_W;
  localparam int NipLo  = DataLo + DATA_W + 3*REG_W;
  localparam int CipLo  = NipLo + IP_W;
  localparam int IoLen  = DATA_W + REG_W + PORT_W + SIZE_W;

  logic [IP_W-1:0]  recCip, recNip;
  logic [IoLen-1:0] recIo;
  logic             fSw, fIoV, fDir, fRep;

  assign recCip = hdrRecord[CipLo +: IP_W];
  assign recNip = hdrRecord[NipLo +: IP_W];
  assign recIo  = hdrRecord[SizeLo +: IoLen];
  assign fSw    = hdrRecord[FlagSw];
  assign fIoV   = hdrRecord[FlagIoValid];
  assign fDir   = hdrRecord[FlagDirIn];
  assign fRep   = hdrRecord[FlagRepStr];

  // R1
  ready_after_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (entryStb && !hdrReady) |=> hdrReady);

  // R1
  ready_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrReady |=> !hdrReady);

  // R9
  ready_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hdrReady) |-> $past(entryStb));

  // R5
  io_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hdrReady && !fIoV) |-> (recIo == '0 && !fDir && !fRep));

  // R4
  rep_collapse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hdrReady && fIoV && fRep) |-> (recCip == recNip));

  // R6
  sw_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    hdrReady |-> $onehot0({fSw, fIoV}));

  // R7
  resume_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |=> resumeValid);

  // R7
  resume_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeValid |-> (resumeAddr == ($past(fIoV) ? $past(recCip) : $past(recNip))));

  // R8
  record_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resumeReq && !entryStb) |=> $stable(hdrRecord));

endmodule

bind smm_hdr_capture smm_hdr_checker #(
  .IP_W   (IP_W),
  .PORT_W (PORT_W),
  .DATA_W (DATA_W),
  .REG_W  (REG_W),
  .SIZE_W (SIZE_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .entryStb    (entryStb),
  .resumeReq   (resumeReq),
  .hdrRecord   (hdrRecord),
  .hdrReady    (hdrReady),
  .resumeValid (resumeValid),
  .resumeAddr  (resumeAddr)
);

// File: tb/tb_smm_hdr_capture.sv
module tb_smm_hdr_capture;

  localparam int ClkPeriod = 10;
  localparam int IP_W   = 32;
  localparam int PORT_W = 16;
  localparam int DATA_W = 32;
  localparam int REG_W  = 32;
  localparam int SIZE_W = 2;
  localparam int HDR_W  = 2*IP_W + 4*REG_W + DATA_W + PORT_W + SIZE_W + 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              entryStb = 1'b0;
  logic [1:0]        entryCause = '0;
  logic [IP_W-1:0]   curIp = '0, nextIp = '0;
  logic [PORT_W-1:0] ioPort = '0;
  logic [SIZE_W-1:0] ioSize = '0;
  logic [DATA_W-1:0] ioData = '0;
  logic              ioDirIn = 1'b0, ioRepString = 1'b0;
  logic [REG_W-1:0]  ioStrPtr = '0, dbgCtl = '0, flagsReg = '0, ctlReg0 = '0;
  logic              resumeReq = 1'b0;
  logic [HDR_W-1:0]  hdrRecord;
  logic              hdrReady, resumeValid;
  logic [IP_W-1:0]   resumeAddr;

  int errors = 0;
  int checks = 0;

  always #(ClkPeriod/2) clk = ~clk;

  smm_hdr_capture dut (
    .clk(clk), .rstN(rstN), .entryStb(entryStb), .entryCause(entryCause),
    .curIp(curIp), .nextIp(nextIp), .ioPort(ioPort), .ioSize(ioSize),
    .ioData(ioData), .ioDirIn(ioDirIn), .ioRepString(ioRepString),
    .ioStrPtr(ioStrPtr), .dbgCtl(dbgCtl), .flagsReg(flagsReg),
    .ctlReg0(ctlReg0), .resumeReq(resumeReq), .hdrRecord(hdrRecord),
    .hdrReady(hdrReady), .resumeValid(resumeValid), .resumeAddr(resumeAddr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [HDR_W-1:0] act, input logic [HDR_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected record from the requirement text
  function automatic logic [HDR_W-1:0] expRec(
      input logic [1:0] c, input logic dIn, input logic rep,
      input logic [IP_W-1:0] cip, input logic [IP_W-1:0] nip,
      input logic [PORT_W-1:0] port, input logic [SIZE_W-1:0] sz,
      input logic [DATA_W-1:0] dat, input logic [REG_W-1:0] ptr,
      input logic [REG_W-1:0] dbg, input logic [REG_W-1:0] efl,
      input logic [REG_W-1:0] cr0);
    logic trap;
    logic [IP_W-1:0] nipE;
    trap = (c == 2'd1);
    nipE = (trap && rep) ? cip : nip;
    return {cip, nipE, dbg, efl, cr0,
            trap ? dat  : {DATA_W{1'b0}},
            trap ? ptr  : {REG_W{1'b0}},
            trap ? port : {PORT_W{1'b0}},
            trap ? sz   : {SIZE_W{1'b0}},
            trap && rep, trap && dIn, trap, c == 2'd2};
  endfunction

  task automatic setInputs(input int k);
    curIp    = 32'hA000_0000 ^ (k * 32'h0001_0203);
    nextIp   = curIp + 32'd2 + 32'(k % 5);
    ioPort   = 16'h0300 + 16'(k * 7);
    ioSize   = 2'(k);
    ioData   = 32'h5A00_0000 + 32'(k * 977);
    ioStrPtr = 32'h0040_0000 + 32'(k * 13);
    dbgCtl   = 32'h0000_0400 | 32'(k);
    flagsReg = 32'h0000_0202 ^ 32'(k << 8);
    ctlReg0  = 32'h8000_0011 + 32'(k);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [HDR_W-1:0] exp;
    logic [IP_W-1:0]  expAddr;
    string tag;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(hdrRecord == '0, "R10 record", hdrRecord, '0);
    check(!hdrReady && !resumeValid, "R10 strobes",
          HDR_W'({hdrReady, resumeValid}), '0);
    check(resumeAddr == '0, "R10 resumeAddr", HDR_W'(resumeAddr), '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 4; c++) begin
      for (int d = 0; d < 2; d++) begin
        for (int r = 0; r < 2; r++) begin
          for (int p = 0; p < 3; p++) begin
            int k;
            k = c * 12 + d * 6 + r * 3 + p;
            setInputs(k);
            if (p == 2) begin
              curIp  = '1;
              nextIp = '0;
            end
            entryCause  = 2'(c);
            ioDirIn     = d[0];
            ioRepString = r[0];
            exp = expRec(2'(c), d[0], r[0], curIp, nextIp, ioPort, ioSize,
                         ioData, ioStrPtr, dbgCtl, flagsReg, ctlReg0);
            expAddr = (c == 1) ? curIp : ((c == 1 && r == 1) ? curIp : nextIp);
            tag = (c == 1) ? (r == 1 ? "R3/R4 trap record" : "R3 trap record")
                           : (c == 2 ? "R5/R6 sw record" : "R2/R5 record");
            entryStb = 1'b1;
            @(negedge clk);
            entryStb = 1'b0;
            setInputs(k + 100);   // inputs move after capture
            check(hdrReady == 1'b1, "R1 ready pulse", HDR_W'(hdrReady), 1);
            check(hdrRecord == exp, tag, hdrRecord, exp);
            @(negedge clk);
            check(hdrReady == 1'b0, "R1 ready single", HDR_W'(hdrReady), 0);
            resumeReq = 1'b1;
            @(negedge clk);
            resumeReq = 1'b0;
            check(resumeValid == 1'b1, "R7 resume valid", HDR_W'(resumeValid), 1);
            check(resumeAddr == expAddr, "R7 resume addr",
                  HDR_W'(resumeAddr), HDR_W'(expAddr));
            check(hdrRecord == exp, "R8 record after resume", hdrRecord, exp);
            @(negedge clk);
            check(resumeValid == 1'b0, "R7 resume single", HDR_W'(resumeValid), 0);
          end
        end
      end
    end

    // R9: strobe held into the presenting cycle is ignored
    setInputs(7);
    entryCause = 2'd1; ioDirIn = 1'b1; ioRepString = 1'b0;
    exp = expRec(2'd1, 1'b1, 1'b0, curIp, nextIp, ioPort, ioSize,
                 ioData, ioStrPtr, dbgCtl, flagsReg, ctlReg0);
    entryStb = 1'b1;
    @(negedge clk);
    setInputs(55);
    entryCause = 2'd2;
    check(hdrReady == 1'b1, "R9 first ready", HDR_W'(hdrReady), 1);
    check(hdrRecord == exp, "R9 first capture", hdrRecord, exp);
    @(negedge clk);
    entryStb = 1'b0;
    check(hdrReady == 1'b0, "R9 no second ready", HDR_W'(hdrReady), 0);
    check(hdrRecord == exp, "R9 record kept", hdrRecord, exp);
    @(negedge clk);
    check(hdrRecord == exp, "R9 record still kept", hdrRecord, exp);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule